// File: doc/BRIEF.md
# Parallel Port Compatible-Mode Receiver

This block sits on the peripheral side of a byte-wide parallel printer link and runs the forward-channel handshake. The host puts a byte on eight data lines and pulls an active-low strobe. The block synchronises the strobe and detects its falling edge. In the same clock it captures the byte and raises BUSY. Once the byte has been written into an on-chip receive FIFO, the block drives an active-low acknowledge pulse. It lowers BUSY in the same clock that the pulse ends.

On the chip side, a first-word-fall-through read port drains the FIFO. Three register inputs set the static status lines: paper empty, selected and an active-low fault. The host's select-in and auto-feed requests are synchronised and brought out as active-high levels. When the host drives its active-low initialise line, the FIFO is flushed and the handshake returns to idle.

All timing is counted in system clock cycles. A clock-frequency parameter converts the 0.5 µs and 10 µs acknowledge limits into cycles.

Top module: `pp_compat_rx`

## Requirements
- R1: After reset, `busy` is 0, `ack_n` is 1 and `rd_valid` is 0.
- R2: A falling edge on `strobe_n` while idle captures `pd` and raises `busy` no later than the third rising clock edge after the strobe level changes. This is well inside 0.5 µs at 100 MHz.
- R3: Captured bytes leave the read port in arrival order. `rd_data` shows the oldest byte while `rd_valid` is 1, and `rd_en` removes it. A read while `rd_valid` is 0 has no effect.
- R4: `ack_n` falls in the clock after the byte is written to the FIFO, which is one clock after `busy` rises. `busy` stays 1 for the whole pulse and falls in the same clock that `ack_n` returns to 1.
- R5: The acknowledge pulse lasts `clamp(cfg_ack_cycles, ACK_MIN, ACK_MAX)` cycles. ACK_MIN is 0.5 µs rounded up to whole cycles and ACK_MAX is 10 µs. At 100 MHz these are 50 and 1000.
- R6: With the FIFO full, a new byte keeps `busy` at 1 and no acknowledge is issued. The byte is stored and acknowledged once a read frees a slot.
- R7: A further falling edge on `strobe_n` while `busy` is 1 is ignored and stores no byte.
- R8: While synchronised `init_n` is 0, the FIFO is emptied, `busy` is 0, `ack_n` is 1 and strobe edges are ignored.
- R9: `paper_empty`, `select` and `fault_n` equal `cfg_paper_empty`, `cfg_select` and the inverse of `cfg_fault` as they were one clock earlier.
- R10: `host_sel_req` and `host_autofeed` are the inverses of `selin_n` and `autofd_n`, delayed by a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd | input | 8 | Host data lines |
| strobe_n | input | 1 | Host data strobe, active low |
| init_n | input | 1 | Host initialise request, active low |
| selin_n | input | 1 | Host select-in, active low |
| autofd_n | input | 1 | Host auto-feed, active low |
| busy | output | 1 | Peripheral busy to host |
| ack_n | output | 1 | Acknowledge pulse to host, active low |
| paper_empty | output | 1 | Paper-empty status to host |
| select | output | 1 | Selected status to host |
| fault_n | output | 1 | Fault status to host, active low |
| host_sel_req | output | 1 | Synchronised select-in request, active high |
| host_autofeed | output | 1 | Synchronised auto-feed request, active high |
| cfg_ack_cycles | input | ACKW (10) | Requested acknowledge width in cycles |
| cfg_paper_empty | input | 1 | Paper-empty status register |
| cfg_select | input | 1 | Selected status register |
| cfg_fault | input | 1 | Fault status register, active high |
| rd_en | input | 1 | Remove the oldest byte from the FIFO |
| rd_data | output | 8 | Oldest received byte |
| rd_valid | output | 1 | FIFO holds at least one byte |

## Verification
The bench requests widths of 0, 200 and 1023 cycles. A design that skipped the clamp would give a zero-length or over-long pulse instead of 50, 200 or 1000 cycles. It fills the FIFO and sends one more byte: a design without back-pressure would acknowledge and lose that byte, or overwrite the oldest one. It toggles the strobe again during an acknowledge, which a design without the idle guard would store as a duplicate byte. It also strobes while initialise is held, which exposes a flush that fails to empty the FIFO or a handshake that leaves `busy` set.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_HOLD  = 2'd1,
    HS_PULSE = 2'd2
  } hs_state_e;

  // Ceiling of clk_hz * ns / 1e9, never below one cycle.
  function automatic int unsigned ns_to_cycles(longint unsigned clk_hz, longint unsigned ns);
    longint unsigned c;
    c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  // Request forced into the legal [lo, hi] window.
  function automatic int unsigned ack_clamp(int unsigned req, int unsigned lo, int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= {W{RST_VAL}};
          else        st[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= {W{RST_VAL}};
          else        st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/pp_rx_fifo.sv
module pp_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr && !full && !flush;
  assign do_rd = rd && !empty && !flush;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pp_hs_fsm.sv
module pp_hs_fsm
  import pp_rx_pkg::*;
#(
  parameter int ACKW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_act,
  input  logic            strb_fall,
  input  logic            fifo_full,
  input  logic [ACKW-1:0] ack_len,
  output logic            cap_en,
  output logic            fifo_wr,
  output logic            ack_done,
  output logic            busy,
  output logic            ack_n
);
  hs_state_e       state, nxt;
  logic [ACKW-1:0] cnt;

  always_comb begin
    nxt      = state;
    cap_en   = 1'b0;
    fifo_wr  = 1'b0;
    ack_done = 1'b0;
    if (init_act) begin
      nxt = HS_IDLE;
    end else begin
      case (state)
        HS_IDLE: if (strb_fall) begin
          cap_en = 1'b1;
          nxt    = HS_HOLD;
        end
        HS_HOLD: if (!fifo_full) begin
          fifo_wr = 1'b1;
          nxt     = HS_PULSE;
        end
        HS_PULSE: if (cnt == '0) begin
          ack_done = 1'b1;
          nxt      = HS_IDLE;
        end
        default: nxt = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
      ack_n <= 1'b1;
    end else begin
      state <= nxt;
      if (fifo_wr)                          cnt <= ack_len - 1'b1;
      else if (state == HS_PULSE && cnt != '0) cnt <= cnt - 1'b1;
      busy  <= (nxt != HS_IDLE);
      ack_n <= (nxt != HS_PULSE);
    end
  end
endmodule

// File: rtl/pp_compat_rx.sv
module pp_compat_rx
  import pp_rx_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ACK_MIN    = ns_to_cycles(CLK_HZ, 500),
  localparam int ACK_MAX    = ns_to_cycles(CLK_HZ, 10_000),
  localparam int ACKW       = $clog2(ACK_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      pd,
  input  logic            strobe_n,
  input  logic            init_n,
  input  logic            selin_n,
  input  logic            autofd_n,
  output logic            busy,
  output logic            ack_n,
  output logic            paper_empty,
  output logic            select,
  output logic            fault_n,
  output logic            host_sel_req,
  output logic            host_autofeed,
  input  logic [ACKW-1:0] cfg_ack_cycles,
  input  logic            cfg_paper_empty,
  input  logic            cfg_select,
  input  logic            cfg_fault,
  input  logic            rd_en,
  output logic [7:0]      rd_data,
  output logic            rd_valid
);
  // Named internal events, observed by the bound checker.
  logic [3:0]      sync_q;
  logic            strb_s, strb_d, strb_fall, init_act;
  logic            cap_en, fifo_wr, fifo_full, fifo_empty, ack_done;
  logic [7:0]      cap_q;
  logic [ACKW-1:0] ack_len;

  pp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({autofd_n, selin_n, init_n, strobe_n}),
    .q    (sync_q)
  );

  assign strb_s    = sync_q[0];
  assign init_act  = !sync_q[1];
  assign strb_fall = strb_d && !strb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_d <= 1'b1;
    else        strb_d <= strb_s;
  end

  always_comb ack_len = ACKW'(ack_clamp(32'(cfg_ack_cycles), ACK_MIN, ACK_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= pd;
  end

  pp_hs_fsm #(.ACKW(ACKW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_act (init_act),
    .strb_fall(strb_fall),
    .fifo_full(fifo_full),
    .ack_len  (ack_len),
    .cap_en   (cap_en),
    .fifo_wr  (fifo_wr),
    .ack_done (ack_done),
    .busy     (busy),
    .ack_n    (ack_n)
  );

  pp_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(init_act),
    .wr   (fifo_wr),
    .wdata(cap_q),
    .rd   (rd_en),
    .rdata(rd_data),
    .full (fifo_full),
    .empty(fifo_empty)
  );

  assign rd_valid = !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paper_empty <= 1'b0;
      select      <= 1'b0;
      fault_n     <= 1'b1;
    end else begin
      paper_empty <= cfg_paper_empty;
      select      <= cfg_select;
      fault_n     <= !cfg_fault;
    end
  end

  assign host_sel_req  = !sync_q[2];
  assign host_autofeed = !sync_q[3];
endmodule

// File: rtl/pp_compat_rx_chk.sv
module pp_compat_rx_chk #(
  parameter int ACKW    = 10,
  parameter int ACK_MIN = 50,
  parameter int ACK_MAX = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic strb_fall,
  input logic init_act,
  input logic fifo_wr,
  input logic fifo_full,
  input logic busy,
  input logic ack_n,
  input logic rd_valid,
  input logic paper_empty,
  input logic select,
  input logic fault_n,
  input logic cfg_paper_empty,
  input logic cfg_select,
  input logic cfg_fault
);
  logic [ACKW:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (!ack_n) low_cnt <= low_cnt + 1'b1;
    else             low_cnt <= '0;
  end

  assert_busy_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && !busy && !init_act) |=> busy);

  assert_ack_inside_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> busy);

  assert_ack_after_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(fifo_wr));

  assert_busy_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($rose(ack_n) || $past(init_act)));

  assert_ack_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_n) && !$past(init_act)) |->
      (low_cnt >= (ACKW+1)'(ACK_MIN) && low_cnt <= (ACKW+1)'(ACK_MAX)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);

  assert_init_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_act |=> (!busy && ack_n && !rd_valid));

  assert_status_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (paper_empty == $past(cfg_paper_empty) &&
                      select == $past(cfg_select) &&
                      fault_n == !$past(cfg_fault)));
endmodule

bind pp_compat_rx pp_compat_rx_chk #(
  .ACKW(ACKW), .ACK_MIN(ACK_MIN), .ACK_MAX(ACK_MAX)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .strb_fall      (strb_fall),
  .init_act       (init_act),
  .fifo_wr        (fifo_wr),
  .fifo_full      (fifo_full),
  .busy           (busy),
  .ack_n          (ack_n),
  .rd_valid       (rd_valid),
  .paper_empty    (paper_empty),
  .select         (select),
  .fault_n        (fault_n),
  .cfg_paper_empty(cfg_paper_empty),
  .cfg_select     (cfg_select),
  .cfg_fault      (cfg_fault)
);

// File: tb/pp_compat_rx_bench.sv
module pp_compat_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pd = '0;
  logic       strobe_n = 1'b1, init_n = 1'b1, selin_n = 1'b1, autofd_n = 1'b1;
  logic       busy, ack_n, paper_empty, select, fault_n, host_sel_req, host_autofeed;
  logic [9:0] cfg_ack_cycles = 10'd200;
  logic       cfg_paper_empty = 1'b0, cfg_select = 1'b0, cfg_fault = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pp_compat_rx u_pp_compat_rx (
    .clk(clk), .rst_n(rst_n), .pd(pd), .strobe_n(strobe_n), .init_n(init_n),
    .selin_n(selin_n), .autofd_n(autofd_n), .busy(busy), .ack_n(ack_n),
    .paper_empty(paper_empty), .select(select), .fault_n(fault_n),
    .host_sel_req(host_sel_req), .host_autofeed(host_autofeed),
    .cfg_ack_cycles(cfg_ack_cycles), .cfg_paper_empty(cfg_paper_empty),
    .cfg_select(cfg_select), .cfg_fault(cfg_fault), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Width the bench expects from the requirement: 50..1000 cycles at 100 MHz.
  function automatic int exp_width(int req);
    if (req < 50)   return 50;
    if (req > 1000) return 1000;
    return req;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Host sends one byte; measures busy rise, ACK start, width and release.
  task automatic send_byte(input logic [7:0] b, input bit glitch, input string tag);
    int busy_at = -1, ack_start = -1, ack_low = 0;
    bit overlap_bad = 0, rel_ok = 0, done = 0;
    @(negedge clk);
    pd = b;
    repeat (5) @(negedge clk);
    strobe_n = 1'b0;
    for (int k = 1; k <= 3000 && !done; k++) begin
      @(negedge clk);
      if (k == 55) strobe_n = 1'b1;
      if (glitch && k == 20) strobe_n = 1'b1;
      if (glitch && k == 23) strobe_n = 1'b0;
      if (busy && busy_at < 0) busy_at = k;
      if (!ack_n) begin
        ack_low++;
        if (ack_start < 0) ack_start = k;
        if (!busy) overlap_bad = 1;
      end else if (ack_start >= 0) begin
        done = 1;
        rel_ok = !busy;
      end
    end
    strobe_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_at >= 1 && busy_at <= 3, "R2", {tag, " busy rise cycle"}, busy_at, 3);
    check(ack_start == busy_at + 1, "R4", {tag, " ack start after store"}, ack_start, busy_at + 1);
    check(!overlap_bad, "R4", {tag, " busy held during ack"}, overlap_bad, 0);
    check(rel_ok, "R4", {tag, " busy falls with ack end"}, rel_ok, 1);
    check(ack_low == exp_width(int'(cfg_ack_cycles)), "R5", {tag, " ack width"},
          ack_low, exp_width(int'(cfg_ack_cycles)));
  endtask

  task automatic pop(input logic [7:0] exp, input string tag);
    @(negedge clk);
    check(rd_valid == 1'b1, "R3", {tag, " rd_valid"}, rd_valid, 1);
    check(rd_data == exp, "R3", {tag, " rd_data"}, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(ack_n == 1'b1, "R1", "ack_n after reset", ack_n, 1);
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
  endtask

  task automatic t_basic;
    cfg_ack_cycles = 10'd200;
    send_byte(8'hA5, 1'b0, "basic0");
    send_byte(8'h3C, 1'b0, "basic1");
    send_byte(8'h00, 1'b0, "basic2");
    pop(8'hA5, "order0");
    pop(8'h3C, "order1");
    pop(8'h00, "order2");
    rd_en = 1'b1;                    // read while empty (R3)
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b0, "R3", "empty read leaves fifo empty", rd_valid, 0);
    send_byte(8'h77, 1'b0, "after empty read");
    pop(8'h77, "after empty read");
  endtask

  task automatic t_width;
    cfg_ack_cycles = 10'd0;          // clamps up to 50 (R5)
    send_byte(8'h11, 1'b0, "width min");
    cfg_ack_cycles = 10'd1023;       // clamps down to 1000 (R5)
    send_byte(8'h22, 1'b0, "width max");
    cfg_ack_cycles = 10'd50;
    send_byte(8'h33, 1'b0, "width edge");
    pop(8'h11, "width");
    pop(8'h22, "width");
    pop(8'h33, "width");
  endtask

  task automatic t_full;
    int ack_seen = 0, busy_drop = 0, ack_at = -1;
    cfg_ack_cycles = 10'd60;
    for (int i = 0; i < 4; i++) send_byte(8'hC0 + 8'(i), 1'b0, "fill");
    @(negedge clk);
    pd = 8'hEE;
    repeat (5) @(negedge clk);
    strobe_n = 1'b0;
    for (int k = 1; k <= 1500; k++) begin
      @(negedge clk);
      if (k == 55) strobe_n = 1'b1;
      if (!ack_n) ack_seen++;
      if (k > 3 && !busy) busy_drop++;
    end
    check(ack_seen == 0, "R6", "no ack while full", ack_seen, 0);
    check(busy_drop == 0, "R6", "busy held while full", busy_drop, 0);
    pop(8'hC0, "full drain0");
    for (int k = 1; k <= 10 && ack_at < 0; k++) begin
      if (!ack_n) ack_at = k;
      else @(negedge clk);
    end
    check(ack_at > 0, "R6", "ack after slot frees", ack_at, 1);
    repeat (80) @(negedge clk);
    check(busy == 1'b0 && ack_n == 1'b1, "R6", "handshake done after free", busy, 0);
    pop(8'hC1, "full drain1");
    pop(8'hC2, "full drain2");
    pop(8'hC3, "full drain3");
    pop(8'hEE, "held byte stored R6");
    @(negedge clk);
    check(rd_valid == 1'b0, "R6", "fifo empty after drain", rd_valid, 0);
  endtask

  task automatic t_ignore;
    cfg_ack_cycles = 10'd200;
    send_byte(8'h5A, 1'b1, "strobe during busy R7");
    pop(8'h5A, "R7 single byte");
    @(negedge clk);
    check(rd_valid == 1'b0, "R7", "no duplicate byte", rd_valid, 0);
  endtask

  task automatic t_init;
    int busy_seen = 0;
    cfg_ack_cycles = 10'd50;
    send_byte(8'h81, 1'b0, "pre-init0");
    send_byte(8'h82, 1'b0, "pre-init1");
    @(negedge clk);
    init_n = 1'b0;
    repeat (5) @(negedge clk);
    check(rd_valid == 1'b0, "R8", "fifo flushed by init", rd_valid, 0);
    pd = 8'h99;
    strobe_n = 1'b0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (busy || !ack_n) busy_seen++;
    end
    strobe_n = 1'b1;
    repeat (3) @(negedge clk);
    init_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_seen == 0, "R8", "strobe ignored during init", busy_seen, 0);
    check(rd_valid == 1'b0, "R8", "no byte stored during init", rd_valid, 0);
    send_byte(8'h4B, 1'b0, "after init R8");
    pop(8'h4B, "after init R8");
  endtask

  task automatic t_status;
    @(negedge clk);
    cfg_paper_empty = 1'b1; cfg_select = 1'b0; cfg_fault = 1'b1;
    @(negedge clk);
    check(paper_empty == 1'b1, "R9", "paper_empty follows", paper_empty, 1);
    check(select == 1'b0, "R9", "select follows", select, 0);
    check(fault_n == 1'b0, "R9", "fault_n inverted", fault_n, 0);
    cfg_paper_empty = 1'b0; cfg_select = 1'b1; cfg_fault = 1'b0;
    @(negedge clk);
    check(paper_empty == 1'b0 && select == 1'b1 && fault_n == 1'b1, "R9",
          "status second pattern", {paper_empty, select, fault_n}, 3'b011);
    selin_n = 1'b0; autofd_n = 1'b1;
    @(negedge clk);
    check(host_sel_req == 1'b0, "R10", "select-in not yet through sync", host_sel_req, 0);
    repeat (2) @(negedge clk);
    check(host_sel_req == 1'b1 && host_autofeed == 1'b0, "R10", "select-in request",
          {host_sel_req, host_autofeed}, 2'b10);
    selin_n = 1'b1; autofd_n = 1'b0;
    repeat (3) @(negedge clk);
    check(host_sel_req == 1'b0 && host_autofeed == 1'b1, "R10", "auto-feed request",
          {host_sel_req, host_autofeed}, 2'b01);
    autofd_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_width();
    t_full();
    t_ignore();
    t_init();
    t_status();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule